// File: doc/BRIEF.md
# Programmable Periodic Sync Pulse Generator

This block drives the frame marker for a streaming signal-processing chain. It emits a strobe one clock cycle wide at a fixed spacing, and downstream counters and pipelines use that strobe to return to their start state in step with frame boundaries. A second output goes high on the cycle after each strobe, which is the first sample of the frame the strobe announces.

The spacing is fixed when the design is built. It is the product of four factors: the number of spectra summed, the number of filter taps, the least common multiple of all reorder-stage orders, and the transform length divided by the number of parallel input lanes. Inside the block, a counter steps from zero to the period minus one and then wraps, and the strobe fires while the count is zero. When the period is a power of two, the counter is a plain free-running binary counter. Any other period uses a compare-and-wrap counter.

A re-arm input returns the count to zero, so that software or system logic can start a new frame phase whenever it needs to. An enable input holds the phase and blocks the strobe while it is low. A small controller tracks the phase with four states:
- `ST_HELD`: reset is asserted or has only just been released.
- `ST_PRIME`: the count is zero and no strobe has been issued since the last reset or re-arm.
- `ST_RUN`: counting.
- `ST_PAUSED`: enable is low after counting has started.

The transitions are:
- HELD→PRIME on the first clock after reset is released.
- Any state→PRIME when re-arm is high.
- PRIME→RUN and PAUSED→RUN when enable is high.
- RUN→PAUSED when enable is low.
- Every other case stays in the current state.

Top module: `sync_marker_gen`

## Requirements
- R1: With no re-arm and enable held high, strobes are exactly PERIOD cycles apart. PERIOD = ACC_COUNT × FIR_TAPS × LCM(all reorder orders) × FFT_SIZE / PAR_INPUTS. The default parameters give 1 × 2 × LCM(2,2,5) × 64/4 = 320.
- R2: `sync_pulse` is high only in a cycle where the internal count is zero and `enable` is high. Unless re-arm is held, it never stays high for two cycles in a row.
- R3: No strobe appears while `rst_n` is low, however long reset is held. On the first clock edge after release the block moves to its primed state. Exactly one strobe then appears in the first cycle after that in which `enable` is high.
- R4: If `rearm` is high at a clock edge, the count is zero in the next cycle, so a strobe appears in the next cycle in which `enable` is high. Later strobes follow at PERIOD spacing from that point.
- R5: While `enable` is low, the count holds its value and no strobe is produced. When `enable` returns high, the phase continues from where it stopped.
- R6: `frame_first` is high in exactly the cycle after each strobe cycle and in no other cycle.
- R7: When PERIOD is a power of two, the block uses a free-running counter of log2(PERIOD) bits. Its strobes follow the same rules at PERIOD spacing; for example, orders {2}, FFT_SIZE 64, PAR_INPUTS 4, FIR_TAPS 2 and ACC_COUNT 2 give 128.
- R8: When PERIOD is not a power of two, the count never exceeds PERIOD−1 and wraps from PERIOD−1 to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Advances the count when high; holds it and blocks the strobe when low |
| rearm | input | 1 | Forces the count back to zero at the next edge |
| sync_pulse | output | 1 | Frame strobe, one cycle wide |
| frame_first | output | 1 | High on the cycle after each strobe (first sample of the frame) |

## Verification
If the count goes wrong, every later strobe moves, so a one-step phase error shows at the next expected strobe, at most PERIOD cycles later. That error also stays present until the next re-arm or reset. If the controller goes wrong, the effect is quicker: a missing or doubled strobe after reset release or re-arm, or a strobe while enable is low, shows up within one or two cycles. A reference model that checks both outputs on every cycle catches either kind of error as soon as it reaches the ports.

// File: rtl/sync_marker_pkg.sv
package sync_marker_pkg;

    typedef enum logic [1:0] {
        ST_HELD   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_RUN    = 2'd2,
        ST_PAUSED = 2'd3
    } mk_state_e;

    localparam int MAX_ORDERS = 32;

    function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Least common multiple of n eight-bit orders packed low lane first.
    function automatic int unsigned lcm_of(input logic [MAX_ORDERS*8-1:0] ords, input int n);
        int unsigned acc;
        int unsigned o;
        acc = 1;
        for (int i = 0; i < n; i++) begin
            o = 32'(ords[i*8 +: 8]);
            if (o != 0) acc = acc / gcd_u(acc, o) * o;
        end
        return acc;
    endfunction

    function automatic int unsigned period_of(
        input logic [MAX_ORDERS*8-1:0] ords,
        input int                      n,
        input int unsigned             fft_size,
        input int unsigned             lanes,
        input int unsigned             taps,
        input int unsigned             accum
    );
        return accum * taps * lcm_of(ords, n) * (fft_size / lanes);
    endfunction

endpackage

// File: rtl/sync_marker_counter.sv
module sync_marker_counter #(
    parameter int unsigned PERIOD = 320,
    parameter int          CW     = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          clr,
    output logic [CW-1:0] count,
    output logic          at_zero
);

    localparam bit          IS_POW2 = ((PERIOD & (PERIOD - 1)) == 0);
    localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);

    generate
        if (IS_POW2) begin : g_free
            // Natural binary rollover performs the wrap.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   count <= '0;
                else if (clr) count <= '0;
                else if (adv) count <= count + 1'b1;
            end
        end else begin : g_wrap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            count <= '0;
                else if (clr)          count <= '0;
                else if (adv) begin
                    if (count == LAST) count <= '0;
                    else               count <= count + 1'b1;
                end
            end

            assert_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
                count <= LAST);
        end
    endgenerate

    assign at_zero = (count == '0);

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(count));

    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && count == LAST) |=> (count == '0));

endmodule

// File: rtl/sync_marker_fsm.sv
module sync_marker_fsm
    import sync_marker_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      rearm,
    input  logic      at_zero,
    output logic      adv,
    output logic      clr,
    output logic      pulse,
    output logic      first,
    output mk_state_e state
);

    mk_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HELD:   state_nx = ST_PRIME;
            ST_PRIME:  if (rearm)        state_nx = ST_PRIME;
                       else if (enable)  state_nx = ST_RUN;
            ST_RUN:    if (rearm)        state_nx = ST_PRIME;
                       else if (!enable) state_nx = ST_PAUSED;
            ST_PAUSED: if (rearm)        state_nx = ST_PRIME;
                       else if (enable)  state_nx = ST_RUN;
            default:   state_nx = ST_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HELD;
        else        state <= state_nx;
    end

    always_comb begin
        clr   = rearm;
        adv   = 1'b0;
        pulse = 1'b0;
        unique case (state)
            ST_HELD: begin
                adv   = 1'b0;
                pulse = 1'b0;
            end
            ST_PRIME, ST_RUN, ST_PAUSED: begin
                adv   = enable && !rearm;
                pulse = enable && at_zero;
            end
            default: begin
                adv   = 1'b0;
                pulse = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) first <= 1'b0;
        else        first <= pulse;
    end

    assert_no_strobe_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD) |-> !pulse);

    assert_held_exits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD) |=> (state == ST_PRIME));

endmodule

// File: rtl/sync_marker_gen.sv
module sync_marker_gen
    import sync_marker_pkg::*;
#(
    parameter int                    NUM_ORDERS = 3,
    parameter logic [NUM_ORDERS*8-1:0] ORDERS   = {8'd5, 8'd2, 8'd2},
    parameter int unsigned           FFT_SIZE   = 64,
    parameter int unsigned           PAR_INPUTS = 4,
    parameter int unsigned           FIR_TAPS   = 2,
    parameter int unsigned           ACC_COUNT  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rearm,
    output logic sync_pulse,
    output logic frame_first
);

    localparam logic [MAX_ORDERS*8-1:0] ORD_PAD = (MAX_ORDERS*8)'(ORDERS);
    localparam int unsigned PERIOD =
        period_of(ORD_PAD, NUM_ORDERS, FFT_SIZE, PAR_INPUTS, FIR_TAPS, ACC_COUNT);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic          adv;
    logic          clr;
    logic          at_zero;
    logic [CW-1:0] count;
    mk_state_e     state;

    sync_marker_counter #(
        .PERIOD (PERIOD),
        .CW     (CW)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .clr     (clr),
        .count   (count),
        .at_zero (at_zero)
    );

    sync_marker_fsm u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .rearm   (rearm),
        .at_zero (at_zero),
        .adv     (adv),
        .clr     (clr),
        .pulse   (sync_pulse),
        .first   (frame_first),
        .state   (state)
    );

    assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && !rearm) |=> !sync_pulse);

    assert_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> enable);

    assert_primed_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIME) |-> (count == '0));

    assert_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> frame_first);

    assert_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_first |-> $past(sync_pulse));

endmodule

// File: tb/sync_marker_gen_test.sv
module sync_marker_gen_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n  = 1'b0;
    logic enable = 1'b0;
    logic rearm  = 1'b0;
    logic sp_a, ff_a, sp_b, ff_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R3";

    sync_marker_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rearm(rearm),
        .sync_pulse(sp_a), .frame_first(ff_a)
    );

    sync_marker_gen #(
        .NUM_ORDERS(1), .ORDERS(8'd2), .FFT_SIZE(64), .PAR_INPUTS(4),
        .FIR_TAPS(2), .ACC_COUNT(2)
    ) uut_pow2 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rearm(rearm),
        .sync_pulse(sp_b), .frame_first(ff_b)
    );

    function automatic int gcd_b(int a, int b);
        while (b != 0) begin
            int t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic int lcm_b(int a, int b);
        return (a / gcd_b(a, b)) * b;
    endfunction

    // Periods derived independently from R1 and R7.
    int p_a = 1 * 2 * lcm_b(lcm_b(2, 2), 5) * (64 / 4);
    int p_b = 2 * 2 * 2 * (64 / 4);

    task automatic check(input bit got, input bit exp, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", cur_req, what, got, exp, cyc);
        end
    endtask

    task automatic check_int(input int got, input int exp, input string req, input string what);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Behavioural reference.
    int cyc = 0;
    int ref_a = 0, ref_b = 0;
    bit held = 1;
    bit eff_a = 0, eff_b = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            held = 1; ref_a = 0; ref_b = 0; eff_a = 0; eff_b = 0;
        end else begin
            eff_a = !held && enable && ref_a == 0;
            eff_b = !held && enable && ref_b == 0;
            if (held) begin
                held = 0;
            end else if (rearm) begin
                ref_a = 0; ref_b = 0;
            end else if (enable) begin
                ref_a = (ref_a + 1) % p_a;
                ref_b = (ref_b + 1) % p_b;
            end
        end
    end

    bit span_on = 0;
    bit have_a = 0, have_b = 0;
    int last_a = 0, last_b = 0;

    always @(negedge clk) begin
        #1;
        if (!done && cyc >= 2) begin
            check(sp_a, rst_n && !held && enable && ref_a == 0, "sync_pulse");
            check(ff_a, rst_n && eff_a, "frame_first");
            check(sp_b, rst_n && !held && enable && ref_b == 0, "sync_pulse pow2 R7");
            check(ff_b, rst_n && eff_b, "frame_first pow2 R7");
            if (span_on) begin
                if (sp_a) begin
                    if (have_a) check_int(cyc - last_a, p_a, "R1", "strobe spacing");
                    last_a = cyc; have_a = 1;
                end
                if (sp_b) begin
                    if (have_b) check_int(cyc - last_b, p_b, "R7", "pow2 strobe spacing");
                    last_b = cyc; have_b = 1;
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(50000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        check_int(p_a, 320, "R1", "derived period");
        check_int(p_b, 128, "R7", "derived pow2 period");
        // R3: reset held with enable high.
        cur_req = "R3";
        step(1);
        enable = 1'b1;
        step(5);
        rst_n = 1'b1;
        step(4);
        // R1, R2, R6, R8: free run.
        cur_req = "R1 R2 R6 R8";
        span_on = 1;
        step(1000);
        span_on = 0;
        // R4: re-arm single, held, and with enable low.
        cur_req = "R4";
        step(37);
        rearm = 1'b1; step(1); rearm = 1'b0;
        step(100);
        rearm = 1'b1; step(3); rearm = 1'b0;
        step(350);
        enable = 1'b0; rearm = 1'b1; step(1); rearm = 1'b0;
        step(5);
        enable = 1'b1;
        step(200);
        // R5: pause, then fast toggling.
        cur_req = "R5";
        enable = 1'b0; step(50); enable = 1'b1;
        step(150);
        for (int i = 0; i < 300; i++) begin
            enable = (i % 3) != 0;
            step(1);
        end
        enable = 1'b1;
        step(400);
        // R3 again: reset mid-run, then resumed spacing.
        cur_req = "R3 R7";
        rst_n = 1'b0; step(4); rst_n = 1'b1;
        have_a = 0; have_b = 0; span_on = 1;
        step(700);
        span_on = 0;
        finish_run();
    end

endmodule